// File: doc/BRIEF.md
# Sequential Signed Multiplier (One Narrow Multiplier, Four Steps)

This block forms the full-width two's complement product of two signed operands. It does not use a full-width multiplier array. It passes four partial products, one per clock, through a single narrow signed multiplier. Each operand is split into two parts. The low part holds the bottom `LO_W` bits with a zero placed above them, so it is never negative. The high part holds the remaining top bits, extended by copies of the sign bit. The partial products are summed in a signed accumulator, which is shifted right arithmetically by `LO_W` between selected steps.

The order of the steps is fixed:
- low×low, whose bottom `LO_W` bits become the lowest product slice;
- shift, then add high(A)×low(B);
- add low(A)×high(B) with no shift, which gives the middle slice;
- shift, then add high×high, which gives the top slice.

The whole product is written to the output register at once, in the cycle before `done` rises.

Operands enter on a valid/ready pair. A request transfers on a rising edge where `start_valid` and `start_ready` are both high. While a multiply is in progress, `start_ready` is low and any `start_valid` is dropped, not queued. The result side has no back-pressure. `done` is a one-cycle notice, and `product` holds its value until the next completion. With the default parameters, each operand is 32 bits, split at bit 17, the narrow multiplier is 18×18, and the accumulator is 48 bits.

Top module: `smul_seq`

## Requirements
- R1: After reset, `start_ready` is 1, `done` is 0 and `product` is all zeros.
- R2: A request is taken on a rising edge where `start_valid` and `start_ready` are both 1. `start_ready` is then 0 for the four cycles that follow that edge, and is 1 again in the cycle in which `done` is 1.
- R3: `done` is 1 for exactly one cycle. That cycle follows the fifth rising edge, counting the edge that took the request as the first.
- R4: In the `done` cycle, `product` equals the 2·OP_W-bit signed product of `op_a` and `op_b`, with both read as two's complement. This includes the cases -2^31×-2^31 = 2^62, any operand times 0, and -1×-1 = 1.
- R5: The result is exact for any legal parameter set (OP_W-LO_W < LO_W+1 and ACC_W > 2·(LO_W+1)). For OP_W=6 and LO_W=4, all 4096 operand pairs give the exact product.
- R6: If `start_valid` is high while `start_ready` is low, the request has no effect. It does not change the result of the multiply in progress and does not cause a second `done`.
- R7: `product` changes only on the edge that raises `done`. At all other times it holds its value, including while the next multiply is running.
- R8: A request presented in the `done` cycle is taken, so back-to-back multiplies complete every five cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | Request carries valid operands |
| start_ready | output | 1 | Block is idle and can take a request |
| op_a | input | OP_W | Signed multiplicand |
| op_b | input | OP_W | Signed multiplier |
| done | output | 1 | One-cycle notice that `product` is new |
| product | output | 2·OP_W | Signed product register |

## Verification
The bench builds two copies of the block. The first uses the default 32/17/48 set. On it the bench checks the signed corners of the 17-bit split point, the most negative operand, zero and -1, together with a pseudo-random sweep, back-to-back requests, a request dropped while busy, and the result holding during a following multiply. The second copy uses OP_W=6, LO_W=4, ACC_W=16. It is small enough that every operand pair can be swept. That sweep covers every combination of high-part sign, low-part value and carry across both slice boundaries.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LL   = 3'd1,
    ST_HL   = 3'd2,
    ST_LH   = 3'd3,
    ST_HH   = 3'd4
  } step_e;
endpackage

// File: rtl/smul_split.sv
module smul_split #(
  parameter int OP_W = 32,
  parameter int LO_W = 17
) (
  input  logic [OP_W-1:0]      op,
  output logic signed [LO_W:0] lo_part,
  output logic signed [LO_W:0] hi_part
);
  localparam int HI_W  = OP_W - LO_W;
  localparam int EXT_W = LO_W + 1 - HI_W;

  // low slice: zero placed on top, so it is never negative
  assign lo_part = {1'b0, op[LO_W-1:0]};
  // high slice: sign bit copied upward
  assign hi_part = {{EXT_W{op[OP_W-1]}}, op[OP_W-1:LO_W]};
endmodule

// File: rtl/smul_narrow.sv
module smul_narrow #(
  parameter int PART_W = 18,
  parameter int ACC_W  = 48
) (
  input  logic signed [PART_W-1:0] mul_x,
  input  logic signed [PART_W-1:0] mul_y,
  output logic signed [ACC_W-1:0]  pp
);
  localparam int FULL_W = 2 * PART_W;

  logic signed [FULL_W-1:0] full;

  assign full = mul_x * mul_y;
  assign pp   = {{(ACC_W-FULL_W){full[FULL_W-1]}}, full};
endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_valid,
  output logic  start_ready,
  output logic  accept,
  output step_e step,
  output logic  done
);
  step_e step_q, step_d;
  logic  done_q;

  assign start_ready = (step_q == ST_IDLE);
  assign accept      = start_valid && start_ready;
  assign step        = step_q;
  assign done        = done_q;

  always_comb begin
    case (step_q)
      ST_IDLE: step_d = accept ? ST_LL : ST_IDLE;
      ST_LL:   step_d = ST_HL;
      ST_HL:   step_d = ST_LH;
      ST_LH:   step_d = ST_HH;
      default: step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      step_q <= step_d;
      done_q <= (step_q == ST_HH);
    end
  end

  // R2: once a request is taken, the block stops offering ready
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !start_ready);

  // R3: completion notice lasts one cycle
  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: a busy sequencer steps forward regardless of start_valid
  assert_busy_advances_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q != ST_IDLE) |=> (step_q != $past(step_q)));
endmodule

// File: rtl/smul_acc.sv
module smul_acc
  import smul_pkg::*;
#(
  parameter int OP_W  = 32,
  parameter int LO_W  = 17,
  parameter int ACC_W = 48
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  step_e                   step,
  input  logic signed [ACC_W-1:0] pp,
  output logic [2*OP_W-1:0]       product
);
  localparam int PROD_W = 2 * OP_W;
  localparam int TOP_W  = PROD_W - 2 * LO_W;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] sum_plain;
  logic signed [ACC_W-1:0] sum_shift;
  logic [LO_W-1:0]         lo_slice_q;
  logic [LO_W-1:0]         mid_slice_q;
  logic [PROD_W-1:0]       prod_q;

  assign sum_plain = acc_q + pp;
  assign sum_shift = (acc_q >>> LO_W) + pp;
  assign product   = prod_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q       <= '0;
      lo_slice_q  <= '0;
      mid_slice_q <= '0;
      prod_q      <= '0;
    end else begin
      case (step)
        ST_LL: begin
          acc_q      <= pp;
          lo_slice_q <= pp[LO_W-1:0];
        end
        ST_HL: acc_q <= sum_shift;
        ST_LH: begin
          acc_q       <= sum_plain;
          mid_slice_q <= sum_plain[LO_W-1:0];
        end
        ST_HH: begin
          acc_q  <= sum_shift;
          prod_q <= {sum_shift[TOP_W-1:0], mid_slice_q, lo_slice_q};
        end
        default: ;
      endcase
    end
  end

  // R4: the last sum must fit the top slice, all bits above it being sign copies
  assert_top_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_HH) |-> ((&sum_shift[ACC_W-1:TOP_W-1]) || !(|sum_shift[ACC_W-1:TOP_W-1])));
endmodule

// File: rtl/smul_seq.sv
module smul_seq
  import smul_pkg::*;
#(
  parameter int OP_W  = 32,
  parameter int LO_W  = 17,
  parameter int ACC_W = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_valid,
  output logic                 start_ready,
  input  logic [OP_W-1:0]      op_a,
  input  logic [OP_W-1:0]      op_b,
  output logic                 done,
  output logic [2*OP_W-1:0]    product
);
  localparam int PART_W = LO_W + 1;

  logic                     accept;
  step_e                    step;
  logic [OP_W-1:0]          a_q, b_q;
  logic signed [PART_W-1:0] a_lo, a_hi, b_lo, b_hi;
  logic signed [PART_W-1:0] mul_x, mul_y;
  logic signed [ACC_W-1:0]  pp;

  smul_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .start_ready (start_ready),
    .accept      (accept),
    .step        (step),
    .done        (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (accept) begin
      a_q <= op_a;
      b_q <= op_b;
    end
  end

  smul_split #(.OP_W(OP_W), .LO_W(LO_W)) u_split_a (
    .op (a_q), .lo_part (a_lo), .hi_part (a_hi)
  );

  smul_split #(.OP_W(OP_W), .LO_W(LO_W)) u_split_b (
    .op (b_q), .lo_part (b_lo), .hi_part (b_hi)
  );

  // pick the operand pair for the current step
  always_comb begin
    case (step)
      ST_HL:   begin mul_x = a_hi; mul_y = b_lo; end
      ST_LH:   begin mul_x = a_lo; mul_y = b_hi; end
      ST_HH:   begin mul_x = a_hi; mul_y = b_hi; end
      default: begin mul_x = a_lo; mul_y = b_lo; end
    endcase
  end

  smul_narrow #(.PART_W(PART_W), .ACC_W(ACC_W)) u_narrow (
    .mul_x (mul_x), .mul_y (mul_y), .pp (pp)
  );

  smul_acc #(.OP_W(OP_W), .LO_W(LO_W), .ACC_W(ACC_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .pp      (pp),
    .product (product)
  );

  // R3: completion follows a taken request by five edges
  assert_done_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start_valid && start_ready, 5));

  // R6: operands are frozen while busy
  assert_ops_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !start_ready |=> ($stable(a_q) && $stable(b_q)));

  // R7: the result moves only with the completion notice
  assert_product_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product));

  // R8: the completion cycle offers ready
  assert_ready_in_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> start_ready);
endmodule

// File: tb/smul_seq_tb.sv
`timescale 1ns/1ps
module smul_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // default configuration
  logic        big_valid = 1'b0;
  logic        big_ready;
  logic [31:0] big_a = '0, big_b = '0;
  logic        big_done;
  logic [63:0] big_prod;

  smul_seq u_dut (
    .clk (clk), .rst_n (rst_n),
    .start_valid (big_valid), .start_ready (big_ready),
    .op_a (big_a), .op_b (big_b),
    .done (big_done), .product (big_prod)
  );

  // small configuration, swept exhaustively
  logic        sm_valid = 1'b0;
  logic        sm_ready;
  logic [5:0]  sm_a = '0, sm_b = '0;
  logic        sm_done;
  logic [11:0] sm_prod;

  smul_seq #(.OP_W(6), .LO_W(4), .ACC_W(16)) u_dut_small (
    .clk (clk), .rst_n (rst_n),
    .start_valid (sm_valid), .start_ready (sm_ready),
    .op_a (sm_a), .op_b (sm_b),
    .done (sm_done), .product (sm_prod)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ref_big(input logic [31:0] a, input logic [31:0] b);
    return longint'($signed(a)) * longint'($signed(b));
  endfunction

  // called just after a falling edge; returns at the falling edge of the done cycle
  task automatic run_big(input logic [31:0] a, input logic [31:0] b);
    bit timing_ok = 1'b1;
    big_valid = 1'b1; big_a = a; big_b = b;
    @(negedge clk);
    big_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (big_done !== 1'b0 || big_ready !== 1'b0) timing_ok = 1'b0;
      @(negedge clk);
    end
    check(timing_ok && big_done === 1'b1 && big_ready === 1'b1,
          "R3 R2 done timing / ready", longint'(big_done), 1);
    check(longint'($signed(big_prod)) == ref_big(a, b), "R4 product",
          longint'($signed(big_prod)), ref_big(a, b));
  endtask

  task automatic run_small(input logic [5:0] a, input logic [5:0] b);
    int exp;
    bit timing_ok = 1'b1;
    exp = int'($signed(a)) * int'($signed(b));
    sm_valid = 1'b1; sm_a = a; sm_b = b;
    @(negedge clk);
    sm_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (sm_done !== 1'b0) timing_ok = 1'b0;
      @(negedge clk);
    end
    check(timing_ok && sm_done === 1'b1 && int'($signed(sm_prod)) == exp,
          "R5 small exhaustive", longint'(int'($signed(sm_prod))), longint'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  logic [31:0] corners [12];
  logic [31:0] held;
  logic [31:0] lfsr_a, lfsr_b;
  bit          quiet;

  initial begin
    corners = '{32'h8000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001,
                32'h7FFF_FFFF, 32'h0001_FFFF, 32'h0002_0000, 32'hFFFE_0000,
                32'hFFFD_FFFF, 32'h0000_FFFF, 32'h1234_5678, 32'hC0DE_4321};
    repeat (3) @(negedge clk);
    // R1: reset state
    check(big_ready === 1'b1, "R1 ready", longint'(big_ready), 1);
    check(big_done === 1'b0, "R1 done", longint'(big_done), 0);
    check(big_prod === 64'd0, "R1 product", longint'(big_prod), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: named corners
    run_big(32'h8000_0000, 32'h8000_0000);
    run_big(32'h0000_0000, 32'h8765_4321);
    run_big(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_big(32'hFFFF_FFFF, 32'h8000_0000);
    // R8: the runs above are back to back; one more pair proves it with done low in between
    @(negedge clk);
    check(big_done === 1'b0, "R3 pulse width", longint'(big_done), 0);

    // R6: request while busy is dropped
    big_valid = 1'b1; big_a = 32'd1000; big_b = 32'hFFFF_FFFD;
    @(negedge clk);
    big_valid = 1'b0;
    @(negedge clk);
    big_valid = 1'b1; big_a = 32'h7FFF_FFFF; big_b = 32'h7FFF_FFFF;
    repeat (3) @(negedge clk);
    big_valid = 1'b0;
    check(big_done === 1'b1 && longint'($signed(big_prod)) == -64'sd3000,
          "R6 busy request ignored", longint'($signed(big_prod)), -3000);
    quiet = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (big_done !== 1'b0 || longint'($signed(big_prod)) != -64'sd3000) quiet = 1'b0;
    end
    check(quiet, "R6 R7 no second done, product held", longint'($signed(big_prod)), -3000);

    // R7: previous result holds during the next multiply
    held = 32'd0;
    big_valid = 1'b1; big_a = 32'd7; big_b = 32'd9;
    @(negedge clk);
    big_valid = 1'b0;
    quiet = 1'b1;
    for (int k = 0; k < 4; k++) begin
      if (longint'($signed(big_prod)) != -64'sd3000) quiet = 1'b0;
      @(negedge clk);
    end
    check(quiet, "R7 hold while busy", longint'($signed(big_prod)), -3000);
    check(big_done === 1'b1 && big_prod == 64'd63, "R7 R4 update at done",
          longint'(big_prod), 63);

    // R8 + R4: all corner pairs, each request in the previous done cycle
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        run_big(corners[i], corners[j]);

    // R4: pseudo-random operands
    lfsr_a = 32'h1357_9BDF;
    lfsr_b = 32'h2468_ACE1;
    for (int n = 0; n < 120; n++) begin
      lfsr_a = lfsr_a ^ (lfsr_a << 13); lfsr_a = lfsr_a ^ (lfsr_a >> 17); lfsr_a = lfsr_a ^ (lfsr_a << 5);
      lfsr_b = lfsr_b ^ (lfsr_b << 13); lfsr_b = lfsr_b ^ (lfsr_b >> 17); lfsr_b = lfsr_b ^ (lfsr_b << 5);
      run_big(lfsr_a, lfsr_b);
    end

    // R5: every pair on the small build
    for (int a = 0; a < 64; a++)
      for (int b = 0; b < 64; b++)
        run_small(6'(a), 6'(b));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule